// File: doc/BRIEF.md
# First-Byte Capture Accumulator Register

This block is an 8-bit register that sits inside a bus-protocol controller and is written from several directions. When a transfer command for an input phase begins, the register arms itself. It then stores the first byte that arrives on the received-byte stream and raises a flag showing that the stored byte is valid. The register re-arms at the start of every input command, including one that repeats the phase of the command before it.

The same register is the accumulator of an internal script engine. A script write either loads an operand or combines the operand with the current contents using AND, OR, XOR or ADD. The result stays readable, so later bit tests can use it, and ADD also reports a carry. While the selection phase is active and the mirror-disable mode bit is clear, the register follows the low byte of the data bus.

The controller also has a host write port and a load-instruction write port. Both are wired to the block, but neither can change the register.

Top module: `fbc_first_byte_reg`

## Requirements
- R1: A `cmd_start` whose `cmd_phase` has bit 0 set (an input phase) arms capture and clears `rd_valid` on the next edge. This happens even when the phase equals that of the previous command.
- R2: Once armed, the first `byte_valid` cycle that is not also a `cmd_start` cycle loads `byte_data` into `rd_data`, sets `rd_valid` and disarms capture. The new value appears one clock after that cycle.
- R3: `host_we`, whatever `host_wdata` holds, leaves `rd_data`, `rd_valid` and `carry_out` unchanged.
- R4: `ld_we`, whatever `ld_wdata` holds, leaves `rd_data`, `rd_valid` and `carry_out` unchanged.
- R5: A `scr_we` with `scr_op` 0 loads `scr_operand`. Op 1 gives AND, op 2 gives OR, op 3 gives XOR and op 4 gives ADD modulo 256, each combining the current value with `scr_operand`. The result is visible one clock later.
- R6: When `sel_active` is 1 and `mirror_dis` is 0, and no script write or capture happens in that cycle, `rd_data` takes `bus_low` on the next clock. When `mirror_dis` is 1, `bus_low` is ignored.
- R7: Synchronous reset sets `rd_data` to 0x00 and clears `rd_valid`, `carry_out` and the armed state.
- R8: Op 4 sets `carry_out` to the carry out of the 8-bit sum. Ops 0 to 3 clear `carry_out`. Capture and mirror leave `carry_out` unchanged.
- R9: Bytes that arrive after the first one of a command leave `rd_data` unchanged until the next input `cmd_start`.
- R10: A `cmd_start` with bit 0 of `cmd_phase` clear (an output phase) disarms capture. It leaves `rd_data` and `rd_valid` unchanged, and later bytes are not captured.
- R11: When a valid script write and a capture fall in the same cycle, the script result is stored, capture is disarmed and `rd_valid` stays 0.
- R12: A `scr_we` with `scr_op` 5, 6 or 7 changes nothing, and a pending capture in that cycle still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Strobe marking the start of a transfer command |
| cmd_phase | input | 3 | Phase code of the starting command; bit 0 set means input |
| byte_valid | input | 1 | A received byte is present on `byte_data` |
| byte_data | input | 8 | Received byte |
| sel_active | input | 1 | Selection phase is active |
| mirror_dis | input | 1 | Mode bit; 1 stops the register following `bus_low` |
| bus_low | input | 8 | Low byte of the data bus |
| scr_we | input | 1 | Script write strobe |
| scr_op | input | 3 | Script operation: 0 load, 1 AND, 2 OR, 3 XOR, 4 ADD |
| scr_operand | input | 8 | Script operand |
| host_we | input | 1 | Host write strobe (ignored) |
| host_wdata | input | 8 | Host write data (ignored) |
| ld_we | input | 1 | Load-instruction write strobe (ignored) |
| ld_wdata | input | 8 | Load-instruction write data (ignored) |
| rd_data | output | 8 | Register contents |
| rd_valid | output | 1 | The captured first byte is valid |
| carry_out | output | 1 | Carry out of the last script ADD |

## Verification
The bench issues a command for each of the eight phase codes and repeats the same input phase twice. A design that re-armed only on a phase change would keep the stale byte. A design that captured on output phases would overwrite the value. A design that kept accepting bytes after the first would hold the last byte instead of the first.

The script ALU is swept over every operand against sixteen accumulator values for each operation, checking both the sum and the carry. This exposes a wrong operation encoding and an off-by-one carry. The bench also drives a script write and a first byte in the same cycle, a reserved op together with a pending capture, host and load-instruction writes with changing data, and the selection mirror with the mode bit both set and clear. A wrong priority shows up as the byte overwriting the script result. A leaky write port shows up as the register taking the ignored data.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

    typedef enum logic [2:0] {
        OP_LOAD = 3'd0,
        OP_AND  = 3'd1,
        OP_OR   = 3'd2,
        OP_XOR  = 3'd3,
        OP_ADD  = 3'd4
    } scr_op_e;

    typedef enum logic [1:0] {
        SRC_HOLD,
        SRC_SCRIPT,
        SRC_CAPTURE,
        SRC_MIRROR
    } upd_src_e;

    typedef struct packed {
        logic armed;
        logic valid;
    } arm_state_t;

    function automatic logic is_input_phase(input logic [2:0] ph);
        return ph[0];
    endfunction

endpackage

// File: rtl/fbc_alu.sv
module fbc_alu #(
    parameter int W = 8
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] operand,
    input  logic [2:0]   op,
    output logic [W-1:0] result,
    output logic         carry_new,
    output logic         op_ok
);
    import fbc_pkg::*;

    logic [W:0] sum;

    always_comb begin
        sum       = {1'b0, acc} + {1'b0, operand};
        result    = acc;
        carry_new = 1'b0;
        op_ok     = 1'b1;
        case (op)
            OP_LOAD: result = operand;
            OP_AND:  result = acc & operand;
            OP_OR:   result = acc | operand;
            OP_XOR:  result = acc ^ operand;
            OP_ADD: begin
                result    = sum[W-1:0];
                carry_new = sum[W];
            end
            default: op_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/fbc_arm_ctrl.sv
module fbc_arm_ctrl #(
    parameter int PW = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_start,
    input  logic [PW-1:0]       cmd_phase,
    input  logic                byte_valid,
    input  logic                scr_take,
    output logic                capture,
    output fbc_pkg::arm_state_t st
);
    import fbc_pkg::*;

    logic start_in;

    assign start_in = cmd_start && is_input_phase(cmd_phase[2:0]);
    assign capture  = st.armed && byte_valid && !cmd_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (cmd_start) begin
            st.armed <= start_in;
            if (start_in) st.valid <= 1'b0;
        end else if (capture) begin
            st.armed <= 1'b0;
            st.valid <= !scr_take;
        end
    end

    // R1: input command start clears the valid flag and arms
    a_r1_rearm: assert property (@(posedge clk) disable iff (rst)
        start_in |=> (st.armed && !st.valid));

    // R2: an uncontested capture marks the byte valid and disarms
    a_r2_valid_set: assert property (@(posedge clk) disable iff (rst)
        (capture && !scr_take) |=> (st.valid && !st.armed));

    // R10: output command start disarms
    a_r10_out_disarm: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && !cmd_phase[0]) |=> !st.armed);

endmodule

// File: rtl/fbc_first_byte_reg.sv
module fbc_first_byte_reg #(
    parameter int DATA_W  = 8,
    parameter int PHASE_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_start,
    input  logic [PHASE_W-1:0] cmd_phase,
    input  logic               byte_valid,
    input  logic [DATA_W-1:0]  byte_data,
    input  logic               sel_active,
    input  logic               mirror_dis,
    input  logic [DATA_W-1:0]  bus_low,
    input  logic               scr_we,
    input  logic [2:0]         scr_op,
    input  logic [DATA_W-1:0]  scr_operand,
    input  logic               host_we,
    input  logic [DATA_W-1:0]  host_wdata,
    input  logic               ld_we,
    input  logic [DATA_W-1:0]  ld_wdata,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_valid,
    output logic               carry_out
);
    import fbc_pkg::*;

    logic [DATA_W-1:0] acc_q;
    logic              carry_q;
    logic [DATA_W-1:0] alu_res;
    logic              alu_carry;
    logic              alu_ok;
    logic              scr_take;
    logic              capture;
    logic              mirror_on;
    arm_state_t        arm_st;
    upd_src_e          src;
    logic              unused_ignored_ports;

    // host and load-instruction writes have no path into the register
    assign unused_ignored_ports = ^{host_we, host_wdata, ld_we, ld_wdata};

    fbc_alu #(.W(DATA_W)) alu_i (
        .acc       (acc_q),
        .operand   (scr_operand),
        .op        (scr_op),
        .result    (alu_res),
        .carry_new (alu_carry),
        .op_ok     (alu_ok)
    );

    assign scr_take  = scr_we && alu_ok;
    assign mirror_on = sel_active && !mirror_dis;

    fbc_arm_ctrl #(.PW(PHASE_W)) arm_i (
        .clk        (clk),
        .rst        (rst),
        .cmd_start  (cmd_start),
        .cmd_phase  (cmd_phase),
        .byte_valid (byte_valid),
        .scr_take   (scr_take),
        .capture    (capture),
        .st         (arm_st)
    );

    always_comb begin
        if (scr_take)       src = SRC_SCRIPT;
        else if (capture)   src = SRC_CAPTURE;
        else if (mirror_on) src = SRC_MIRROR;
        else                src = SRC_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            case (src)
                SRC_SCRIPT: begin
                    acc_q   <= alu_res;
                    carry_q <= alu_carry;
                end
                SRC_CAPTURE: acc_q <= byte_data;
                SRC_MIRROR:  acc_q <= bus_low;
                default:     acc_q <= acc_q;
            endcase
        end
    end

    assign rd_data   = acc_q;
    assign rd_valid  = arm_st.valid;
    assign carry_out = carry_q;

    // R3 R4: ignored write ports cannot move the register
    a_r3_r4_ports_ignored: assert property (@(posedge clk) disable iff (rst)
        ((host_we || ld_we) && !scr_we && !byte_valid && !mirror_on)
        |=> $stable(rd_data));

    // R11: script write beats a same-cycle capture
    a_r11_script_wins: assert property (@(posedge clk) disable iff (rst)
        (scr_take && capture) |=> (rd_data == $past(alu_res) && !rd_valid));

    // R6: mirror follows the bus when nothing else writes
    a_r6_mirror: assert property (@(posedge clk) disable iff (rst)
        (mirror_on && !scr_we && !byte_valid) |=> (rd_data == $past(bus_low)));

    // R9: bytes while disarmed leave the value alone
    a_r9_late_bytes: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !arm_st.armed && !scr_we && !mirror_on) |=> $stable(rd_data));

    // R12: reserved op leaves carry untouched
    a_r12_reserved_op: assert property (@(posedge clk) disable iff (rst)
        (scr_we && scr_op > 3'd4) |=> $stable(carry_out));

endmodule

// File: tb/fbc_first_byte_reg_tb.sv
module fbc_first_byte_reg_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_start;
    logic [2:0] cmd_phase;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       sel_active;
    logic       mirror_dis;
    logic [7:0] bus_low;
    logic       scr_we;
    logic [2:0] scr_op;
    logic [7:0] scr_operand;
    logic       host_we;
    logic [7:0] host_wdata;
    logic       ld_we;
    logic [7:0] ld_wdata;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic       carry_out;

    int tests  = 0;
    int fails  = 0;
    int cycles = 0;
    logic done = 1'b0;

    logic [7:0] e_data;
    logic       e_valid;
    logic       e_carry;

    always #(CLK_PERIOD/2) clk = ~clk;

    fbc_first_byte_reg dut_i (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_phase(cmd_phase),
        .byte_valid(byte_valid), .byte_data(byte_data), .sel_active(sel_active),
        .mirror_dis(mirror_dis), .bus_low(bus_low), .scr_we(scr_we),
        .scr_op(scr_op), .scr_operand(scr_operand), .host_we(host_we),
        .host_wdata(host_wdata), .ld_we(ld_we), .ld_wdata(ld_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .carry_out(carry_out)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        cmd_start = 0; cmd_phase = 0; byte_valid = 0; byte_data = 0;
        sel_active = 0; mirror_dis = 0; bus_low = 0; scr_we = 0; scr_op = 0;
        scr_operand = 0; host_we = 0; host_wdata = 0; ld_we = 0; ld_wdata = 0;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk({req, " data"}, rd_data, e_data);
        chk({req, " valid"}, {7'd0, rd_valid}, {7'd0, e_valid});
        chk({req, " carry"}, {7'd0, carry_out}, {7'd0, e_carry});
    endtask

    function automatic logic [8:0] model_alu(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
        case (op)
            3'd0: return {1'b0, b};
            3'd1: return {1'b0, a & b};
            3'd2: return {1'b0, a | b};
            3'd3: return {1'b0, a ^ b};
            default: return {1'b0, a} + {1'b0, b};
        endcase
    endfunction

    task automatic scr(input logic [2:0] op, input logic [7:0] v);
        logic [8:0] r;
        scr_we = 1; scr_op = op; scr_operand = v;
        tick();
        idle();
        if (op <= 3'd4) begin
            r = model_alu(op, e_data, v);
            e_data = r[7:0];
            e_carry = r[8];
        end
    endtask

    task automatic start_cmd(input logic [2:0] ph);
        cmd_start = 1; cmd_phase = ph;
        tick();
        idle();
        if (ph[0]) e_valid = 0;
    endtask

    task automatic send(input logic [7:0] b);
        byte_valid = 1; byte_data = b;
        tick();
        idle();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        tick(); tick();
        rst = 0;
        e_data = 0; e_valid = 0; e_carry = 0;
        // R7 reset state
        chk_all("R7");

        // R1 R2 R10 R9: every phase code, first byte captured only for inputs
        for (int ph = 0; ph < 8; ph++) begin
            logic [7:0] b1, b2;
            b1 = 8'(ph * 37 + 5);
            b2 = 8'(ph * 11 + 200);
            start_cmd(3'(ph));
            chk_all(ph[0] ? "R1 arm" : "R10 arm");
            send(b1);
            if (ph[0]) begin e_data = b1; e_valid = 1; end
            chk_all(ph[0] ? "R2 capture" : "R10 no capture");
            send(b2);
            chk_all("R9 later byte");
        end

        // R1 same phase twice re-arms
        start_cmd(3'd7); send(8'h3C); e_data = 8'h3C; e_valid = 1;
        chk_all("R1 first");
        start_cmd(3'd7); chk_all("R1 rearm clears valid");
        send(8'hC3); e_data = 8'hC3; e_valid = 1;
        chk_all("R1 same phase");

        // R2 byte in the same cycle as command start is not the first byte
        cmd_start = 1; cmd_phase = 3'd1; byte_valid = 1; byte_data = 8'h11;
        tick(); idle(); e_valid = 0;
        chk_all("R2 same-cycle byte");
        send(8'h22); e_data = 8'h22; e_valid = 1;
        chk_all("R2 next byte");

        // R3 R4: ignored write ports
        for (int i = 0; i < 16; i++) begin
            host_we = 1; host_wdata = 8'(i * 19 + 1);
            tick(); idle();
            chk_all("R3 host write");
            ld_we = 1; ld_wdata = 8'(i * 23 + 7);
            tick(); idle();
            chk_all("R4 load write");
        end

        // R5 R8: ALU sweep
        for (int a = 0; a < 256; a += 17) begin
            for (int b = 0; b < 256; b++) begin
                for (int op = 1; op <= 4; op++) begin
                    scr(3'd0, 8'(a));
                    scr(3'(op), 8'(b));
                    chk(op == 4 ? "R8 add" : "R5 logic", rd_data, e_data);
                    chk("R8 carry", {7'd0, carry_out}, {7'd0, e_carry});
                end
            end
        end
        scr(3'd0, 8'h5A);
        chk_all("R5 load");

        // R12 reserved ops change nothing
        scr(3'd4, 8'hF0);
        chk_all("R8 carry set");
        for (int op = 5; op < 8; op++) begin
            scr(3'(op), 8'hFF);
            chk_all("R12 reserved");
        end
        // R12 reserved op with pending capture: capture proceeds
        start_cmd(3'd3);
        scr_we = 1; scr_op = 3'd6; scr_operand = 8'h77; byte_valid = 1; byte_data = 8'h99;
        tick(); idle(); e_data = 8'h99; e_valid = 1;
        chk_all("R12 capture with reserved");

        // R11 script beats capture
        start_cmd(3'd5);
        scr_we = 1; scr_op = 3'd0; scr_operand = 8'hA5; byte_valid = 1; byte_data = 8'h42;
        tick(); idle(); e_data = 8'hA5; e_carry = 0; e_valid = 0;
        chk_all("R11 script wins");
        send(8'h42);
        chk_all("R11 disarmed");

        // R6 mirror
        for (int i = 0; i < 8; i++) begin
            sel_active = 1; mirror_dis = 0; bus_low = 8'(i * 29 + 3);
            tick(); idle(); e_data = 8'(i * 29 + 3);
            chk_all("R6 mirror on");
            sel_active = 1; mirror_dis = 1; bus_low = 8'(i * 31 + 9);
            tick(); idle();
            chk_all("R6 mirror off");
        end

        // R8 capture leaves carry
        scr(3'd4, 8'hFF);
        start_cmd(3'd1); send(8'h10); e_data = 8'h10; e_valid = 1;
        chk_all("R8 carry kept on capture");

        // R7 reset clears everything
        rst = 1; tick(); rst = 0; e_data = 0; e_valid = 0; e_carry = 0;
        chk_all("R7 reset again");
        send(8'h55);
        chk_all("R7 disarmed after reset");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule